// File: doc/BRIEF.md
# Sticky Alarm and Clock-Failure Status Byte

This block keeps three sticky event flags in one readable status byte: a flag for each of two alarm comparators and a flag that records a loss of the oscillator. Hardware sets each flag. Software can only clear a flag, by writing a zero to its bit position. A write that carries a one leaves that bit as it was, so software can acknowledge one flag without disturbing the others. The same write can never create an event.

The oscillator-loss flag is set at reset, so software always sees that the time base has to be checked after power-up. A write of zero does not clear it while the "no oscillation" input is still high. That input is assumed to be already synchronised to the block clock. The flags are also driven out as separate levels, for the interrupt routing next to this block.

Writes reach the block as a one-cycle strobe with an address and a data byte. Only the status address is decoded. Each flag changes on the clock edge that samples its set event or its clearing write, so the new value is visible one cycle later.

Top module: `alarm_status_reg`

## Requirements
- R1: After reset the status byte reads 0x80: the oscillator-loss flag is 1 and both alarm flags are 0.
- R2: Status bits 6 down to 2 always read 0, whatever is written to them.
- R3: A pulse on `alarm1_hit` sets status bit 0 on the next clock edge.
- R4: A pulse on `alarm2_hit` sets status bit 1 on the next clock edge.
- R5: A write to the status address with a 0 in bit 0 or bit 1 clears that alarm flag. A 1 in that position leaves the flag unchanged, and a write never sets a flag.
- R6: A write to any address other than the status address (default 0xF) leaves the status byte unchanged.
- R7: While `osc_dead` is 1, status bit 7 is set on the next clock edge.
- R8: A write with 0 in bit 7 clears the oscillator-loss flag only if `osc_dead` is 0 in that cycle. Writing 1 to bit 7 never sets it.
- R9: When a set event and a clearing write for the same flag fall in the same cycle, the flag ends up 1.
- R10: `a1_level`, `a2_level` and `osf_level` always equal status bits 0, 1 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm1_hit | input | 1 | One-cycle match pulse from alarm comparator 1 |
| alarm2_hit | input | 1 | One-cycle match pulse from alarm comparator 2 |
| osc_dead | input | 1 | Synchronised level, 1 while no oscillation is detected |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register write address |
| wr_data | input | 8 | Register write data |
| status_q | output | 8 | Readable status byte |
| a1_level | output | 1 | Alarm 1 flag level |
| a2_level | output | 1 | Alarm 2 flag level |
| osf_level | output | 1 | Oscillator-loss flag level |

## Verification
A wrong flag value is visible at once on the status byte and on its level output. A missed set, a wrong clear or a failed hold therefore shows up in the cycle after the edge that caused it. The flags hold their value, so an error stays visible until the next valid clearing write or the next reset. The directed tests count the cycle from each event and sample one cycle later. They cover the two cases a simpler design gets wrong: a write of zero that arrives together with a set event, and a write of zero to the oscillator-loss flag while the failure is still present.

// File: rtl/alarm_status_reg.sv
module alarm_status_reg #(
  parameter int ADDR_W    = 4,
  parameter int STAT_ADDR = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alarm1_hit,
  input  logic              alarm2_hit,
  input  logic              osc_dead,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        status_q,
  output logic              a1_level,
  output logic              a2_level,
  output logic              osf_level
);
  localparam int A1_BIT  = 0;
  localparam int A2_BIT  = 1;
  localparam int OSF_BIT = 7;
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(STAT_ADDR);

  logic wr_hit;
  logic a1_q, a2_q, osf_q;
  logic a1_clr, a2_clr, osf_clr;

  assign wr_hit  = wr_en && (wr_addr == HIT_ADDR);
  assign a1_clr  = wr_hit && !wr_data[A1_BIT];
  assign a2_clr  = wr_hit && !wr_data[A2_BIT];
  assign osf_clr = wr_hit && !wr_data[OSF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1_q  <= 1'b0;
      a2_q  <= 1'b0;
      osf_q <= 1'b1;
    end else begin
      a1_q  <= alarm1_hit | (a1_q  & ~a1_clr);
      a2_q  <= alarm2_hit | (a2_q  & ~a2_clr);
      osf_q <= osc_dead   | (osf_q & ~osf_clr);
    end
  end

  assign status_q  = {osf_q, 5'b0, a2_q, a1_q};
  assign a1_level  = a1_q;
  assign a2_level  = a2_q;
  assign osf_level = osf_q;

  assert_a1_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alarm1_hit |=> status_q[A1_BIT]);
  assert_a2_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    alarm2_hit |=> status_q[A2_BIT]);
  assert_no_write_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm1_hit && !alarm2_hit && status_q[1:0] == 2'b00) |=> status_q[1:0] == 2'b00);
  assert_foreign_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != HIT_ADDR && !alarm1_hit && !alarm2_hit && !osc_dead)
      |=> $stable(status_q));
  assert_osf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    osc_dead |=> osf_level);
  assert_osf_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (osf_level && !(wr_en && wr_addr == HIT_ADDR && !wr_data[OSF_BIT])) |=> osf_level);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm1_hit && wr_en && wr_addr == HIT_ADDR && !wr_data[A1_BIT]) |=> a1_level);
endmodule

// File: tb/sim_alarm_status_reg.sv
module sim_alarm_status_reg;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alarm1_hit = 1'b0, alarm2_hit = 1'b0, osc_dead = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = 4'h0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] status_q;
  logic a1_level, a2_level, osf_level;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_status_reg u0 (
    .clk(clk), .rst_n(rst_n), .alarm1_hit(alarm1_hit), .alarm2_hit(alarm2_hit),
    .osc_dead(osc_dead), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .status_q(status_q), .a1_level(a1_level), .a2_level(a2_level), .osf_level(osf_level)
  );

  task automatic chk(input string req, input logic [7:0] exp);
    logic [7:0] lv;
    checks++;
    lv = {osf_level, 5'b0, a2_level, a1_level};
    if (status_q !== exp || lv !== exp) begin
      errors++;
      $display("FAIL %s status=%h levels=%h expected=%h", req, status_q, lv, exp);
    end
  endtask

  // one-cycle stimulus driven at negedge, result sampled at the following negedge
  task automatic cyc(input logic a1, input logic a2, input logic we,
                     input logic [3:0] ad, input logic [7:0] d);
    alarm1_hit = a1; alarm2_hit = a2; wr_en = we; wr_addr = ad; wr_data = d;
    @(negedge clk);
    alarm1_hit = 0; alarm2_hit = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
  endtask

  task automatic t_reset;
    rst_n = 0;
    @(negedge clk);
    chk("R1 reset value", 8'h80);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 8'h80);
  endtask

  task automatic t_alarms;
    cyc(0, 0, 1, 4'hF, 8'h00);
    chk("R8 osf cleared with oscillation", 8'h00);
    cyc(1, 0, 0, 4'h0, 8'h00);
    chk("R3 alarm1 set, R10 levels", 8'h01);
    cyc(0, 1, 0, 4'h0, 8'h00);
    chk("R4 alarm2 set", 8'h03);
  endtask

  task automatic t_writes;
    cyc(0, 0, 1, 4'hF, 8'hFF);
    chk("R5 R2 write ones no effect", 8'h03);
    cyc(0, 0, 1, 4'hF, 8'hFE);
    chk("R5 clear alarm1 only", 8'h02);
    cyc(0, 0, 1, 4'hE, 8'h00);
    chk("R6 foreign address", 8'h02);
    cyc(0, 0, 1, 4'hF, 8'h7C);
    chk("R5 R8 R2 write to pad and osf", 8'h00);
  endtask

  task automatic t_race;
    cyc(1, 0, 1, 4'hF, 8'h00);
    chk("R9 alarm1 set beats clear", 8'h01);
    cyc(1, 1, 1, 4'hF, 8'h00);
    chk("R9 both alarms beat clear", 8'h03);
    cyc(0, 0, 1, 4'hF, 8'h00);
    chk("R5 clear both", 8'h00);
  endtask

  task automatic t_osf;
    osc_dead = 1;
    cyc(0, 0, 0, 4'h0, 8'h00);
    chk("R7 osf set on failure", 8'h80);
    cyc(1, 0, 1, 4'hF, 8'h00);
    chk("R8 osf kept while dead, R9", 8'h81);
    osc_dead = 0;
    cyc(0, 0, 0, 4'h0, 8'h00);
    chk("R8 osf holds without write", 8'h81);
    cyc(0, 0, 1, 4'hF, 8'h7F);
    chk("R8 osf cleared, alarm1 kept", 8'h01);
  endtask

  task automatic t_midreset;
    cyc(0, 1, 0, 4'h0, 8'h00);
    chk("R4 alarm2 set before reset", 8'h03);
    rst_n = 0;
    #1;
    chk("R1 async reset", 8'h80);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after second release", 8'h80);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_alarms();
    t_writes();
    t_race();
    t_osf();
    t_midreset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule